// File: doc/BRIEF.md
# Dual-Clock Mailbox Register Pair

This block holds two single-word message registers that let two ports of a bidirectional FIFO pass a word to each other without going through FIFO storage. Port A runs on `clkA` and port B on `clkB`, and the two clocks are unrelated. The first mailbox is loaded from port A and drained by port B. The second mailbox is loaded from port B and drained by port A. Each mailbox has an active-low full flag in its writer's clock domain. While a flag is low, further loads into that mailbox are refused.

The events that load and drain a mailbox are carried between the clock domains as toggles through two-flop synchronizers. The reader sees a new word two of its own edges after the load. The writer sees its flag rise two of its own edges after the drain.

Each port also has an output selector. It picks either its incoming mailbox or the FIFO output word presented to the block, and it raises an output-enable whenever the port is in a read cycle. FIFO storage and bus-width conversion are outside this block.

Top module: `mbx_dual_mailbox`

## Requirements
- R1: While `rst1N` is low, `mail1FullN` is 1 and the first mailbox reads as zero. While `rst2N` is low, `mail2FullN` is 1 and the second mailbox reads as zero.
- R2: A `clkA` rising edge with `enA`=1, `wrRdA`=1 (write), `mbA`=1 and `mail1FullN`=1 stores `aDataIn` in the first mailbox, and `mail1FullN` is 0 after that edge.
- R3: A port A mailbox write made while `mail1FullN`=0 leaves the first mailbox contents unchanged.
- R4: A `clkB` edge with `enB`=1, `wrRdB`=1 (read) and `mbB`=1 drains the first mailbox if at least two earlier `clkB` edges followed its load. `mail1FullN` then returns to 1 after the second following `clkA` edge.
- R5: A port B mailbox read made while the first mailbox holds no unread word, as seen in the `clkB` domain, changes no flag. `bDataOut` still shows the old contents.
- R6: A `clkB` rising edge with `enB`=1, `wrRdB`=0 (write), `mbB`=1 and `mail2FullN`=1 stores `bDataIn` in the second mailbox, and `mail2FullN` is 0 after that edge.
- R7: A port B mailbox write made while `mail2FullN`=0 leaves the second mailbox contents unchanged.
- R8: A `clkA` edge with `enA`=1, `wrRdA`=0 (read) and `mbA`=1 drains the second mailbox if at least two earlier `clkA` edges followed its load. `mail2FullN` returns to 1 after the second following `clkB` edge. A read with no unread word has no effect.
- R9: `aOutEn` equals the inverse of `wrRdA`. `aDataOut` is the second mailbox when `mbA`=1 and `fifo2Out` when `mbA`=0.
- R10: `bOutEn` equals `wrRdB`. `bDataOut` is the first mailbox when `mbB`=1 and `fifo1Out` when `mbB`=0.
- R11: With `enA`=0 or `enB`=0, that port's edges neither load nor drain any mailbox.
- R12: Lowering `rst1N` during operation forces `mail1FullN` to 1 and clears the first mailbox, and leaves the second mailbox and its flag untouched. `rst2N` acts the same way on the second mailbox.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkA | input | 1 | Port A clock |
| clkB | input | 1 | Port B clock |
| rst1N | input | 1 | Asynchronous active-low reset of the A-to-B path (first mailbox) |
| rst2N | input | 1 | Asynchronous active-low reset of the B-to-A path (second mailbox) |
| enA | input | 1 | Port A cycle enable |
| wrRdA | input | 1 | Port A direction, 1 = write, 0 = read |
| mbA | input | 1 | Port A mailbox select, 1 = mailbox, 0 = FIFO |
| aDataIn | input | DATA_W | Port A write data |
| fifo2Out | input | DATA_W | FIFO output word offered to port A |
| aDataOut | output | DATA_W | Port A read data |
| aOutEn | output | 1 | Port A output enable |
| mail1FullN | output | 1 | First mailbox full flag, active low, clkA domain |
| enB | input | 1 | Port B cycle enable |
| wrRdB | input | 1 | Port B direction, 0 = write, 1 = read |
| mbB | input | 1 | Port B mailbox select, 1 = mailbox, 0 = FIFO |
| bDataIn | input | DATA_W | Port B write data |
| fifo1Out | input | DATA_W | FIFO output word offered to port B |
| bDataOut | output | DATA_W | Port B read data |
| bOutEn | output | 1 | Port B output enable |
| mail2FullN | output | 1 | Second mailbox full flag, active low, clkB domain |

## Verification
The interesting collision is a writer that keeps retrying a load on the very edge where the drain acknowledgement finally arrives. That attempt must still be refused, and the attempt on the next edge is accepted. A related collision is a reader that keeps reading while a fresh load is still crossing the synchronizer, which must have no effect until the word becomes visible. Both are provoked by forking a writer that retries a mailbox load on every edge of its clock against a reader that requests the same mailbox on every edge of the other clock. The two clocks are chosen so their edges never coincide. A behavioural model counts edges since each load and drain, and the flags and output words are compared against it after every edge of either clock.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // Load strobes from control to datapath. Each one belongs to the clock
  // domain of the mailbox writer.
  typedef struct packed {
    logic load1;  // clkA domain: capture aDataIn into mailbox 1
    logic load2;  // clkB domain: capture bDataIn into mailbox 2
  } mbxStrobe_t;

  localparam int unsigned NUM_CHAN = 2;

endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);

  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[LAST-1:0], d};
      end
    end
  endgenerate

  assign q = chain[LAST];

endmodule

// File: rtl/mbx_handshake.sv
module mbx_handshake #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic wrClk,
  input  logic rdClk,
  input  logic rstN,
  input  logic wrReq,   // mailbox write requested (writer domain)
  input  logic rdReq,   // mailbox read requested (reader domain)
  output logic fullN,   // active-low full flag (writer domain)
  output logic load     // accepted write (writer domain)
);

  logic wrTgl;        // flips on every accepted load
  logic rdTgl;        // flips on every accepted drain
  logic wrTglAtRd;    // wrTgl seen in the reader domain
  logic rdTglAtWr;    // rdTgl seen in the writer domain
  logic validRd;      // unread word visible to the reader
  logic take;         // accepted drain

  mbx_sync #(.STAGES(SYNC_STAGES)) u_wrToRd (
    .clk (rdClk),
    .rstN(rstN),
    .d   (wrTgl),
    .q   (wrTglAtRd)
  );

  mbx_sync #(.STAGES(SYNC_STAGES)) u_rdToWr (
    .clk (wrClk),
    .rstN(rstN),
    .d   (rdTgl),
    .q   (rdTglAtWr)
  );

  assign fullN   = (wrTgl == rdTglAtWr);
  assign load    = wrReq & fullN;
  assign validRd = (wrTglAtRd != rdTgl);
  assign take    = rdReq & validRd;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN)     wrTgl <= 1'b0;
    else if (load) wrTgl <= ~wrTgl;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)     rdTgl <= 1'b0;
    else if (take) rdTgl <= ~rdTgl;
  end

  // An accepted load drops the writer's flag on the same edge.
  p_full_after_load_r2_r6: assert property (
    @(posedge wrClk) disable iff (!rstN) load |=> !fullN
  );

  // A word visible to the reader implies the writer still sees the box full.
  p_valid_implies_full_r4_r8: assert property (
    @(posedge rdClk) disable iff (!rstN) validRd |-> !fullN
  );

  // The flag cannot rise while the reader still has the word pending.
  p_no_early_release_r5: assert property (
    @(posedge wrClk) disable iff (!rstN) $rose(fullN) |-> !validRd
  );

endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clkA,
  input  logic       clkB,
  input  logic       rst1N,
  input  logic       rst2N,
  input  logic       enA,
  input  logic       wrRdA,
  input  logic       mbA,
  input  logic       enB,
  input  logic       wrRdB,
  input  logic       mbB,
  output mbxStrobe_t strobe,
  output logic       mail1FullN,
  output logic       mail2FullN
);

  // Port A: wrRdA high = write. Port B: wrRdB low = write.
  logic aMbxWr, aMbxRd, bMbxWr, bMbxRd;

  assign aMbxWr = enA &  wrRdA & mbA;
  assign aMbxRd = enA & ~wrRdA & mbA;
  assign bMbxWr = enB & ~wrRdB & mbB;
  assign bMbxRd = enB &  wrRdB & mbB;

  // Channel 0 = mailbox 1 (A writes, B reads); channel 1 = mailbox 2.
  logic [NUM_CHAN-1:0] chWrClk, chRdClk, chRstN, chWrReq, chRdReq;
  logic [NUM_CHAN-1:0] chFullN, chLoad;

  assign chWrClk = {clkB,   clkA};
  assign chRdClk = {clkA,   clkB};
  assign chRstN  = {rst2N,  rst1N};
  assign chWrReq = {bMbxWr, aMbxWr};
  assign chRdReq = {aMbxRd, bMbxRd};

  generate
    for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_chan
      mbx_handshake #(.SYNC_STAGES(SYNC_STAGES)) u_hs (
        .wrClk(chWrClk[ch]),
        .rdClk(chRdClk[ch]),
        .rstN (chRstN[ch]),
        .wrReq(chWrReq[ch]),
        .rdReq(chRdReq[ch]),
        .fullN(chFullN[ch]),
        .load (chLoad[ch])
      );
    end
  endgenerate

  assign strobe.load1 = chLoad[0];
  assign strobe.load2 = chLoad[1];
  assign mail1FullN   = chFullN[0];
  assign mail2FullN   = chFullN[1];

endmodule

// File: rtl/mbx_datapath.sv
module mbx_datapath
  import mbx_pkg::*;
#(
  parameter int unsigned DATA_W = 36
) (
  input  logic              clkA,
  input  logic              clkB,
  input  logic              rst1N,
  input  logic              rst2N,
  input  mbxStrobe_t        strobe,
  input  logic              wrRdA,
  input  logic              mbA,
  input  logic [DATA_W-1:0] aDataIn,
  input  logic [DATA_W-1:0] fifo2Out,
  input  logic              wrRdB,
  input  logic              mbB,
  input  logic [DATA_W-1:0] bDataIn,
  input  logic [DATA_W-1:0] fifo1Out,
  output logic [DATA_W-1:0] aDataOut,
  output logic              aOutEn,
  output logic [DATA_W-1:0] bDataOut,
  output logic              bOutEn,
  output logic [DATA_W-1:0] mail1Q,
  output logic [DATA_W-1:0] mail2Q
);

  always_ff @(posedge clkA or negedge rst1N) begin
    if (!rst1N)            mail1Q <= '0;
    else if (strobe.load1) mail1Q <= aDataIn;
  end

  always_ff @(posedge clkB or negedge rst2N) begin
    if (!rst2N)            mail2Q <= '0;
    else if (strobe.load2) mail2Q <= bDataIn;
  end

  // Output selectors: a port drives only during its read cycles.
  assign aOutEn   = ~wrRdA;
  assign aDataOut = mbA ? mail2Q : fifo2Out;
  assign bOutEn   = wrRdB;
  assign bDataOut = mbB ? mail1Q : fifo1Out;

endmodule

// File: rtl/mbx_dual_mailbox.sv
module mbx_dual_mailbox
  import mbx_pkg::*;
#(
  parameter int unsigned DATA_W      = 36,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clkA,
  input  logic              clkB,
  input  logic              rst1N,
  input  logic              rst2N,
  input  logic              enA,
  input  logic              wrRdA,
  input  logic              mbA,
  input  logic [DATA_W-1:0] aDataIn,
  input  logic [DATA_W-1:0] fifo2Out,
  output logic [DATA_W-1:0] aDataOut,
  output logic              aOutEn,
  output logic              mail1FullN,
  input  logic              enB,
  input  logic              wrRdB,
  input  logic              mbB,
  input  logic [DATA_W-1:0] bDataIn,
  input  logic [DATA_W-1:0] fifo1Out,
  output logic [DATA_W-1:0] bDataOut,
  output logic              bOutEn,
  output logic              mail2FullN
);

  mbxStrobe_t        strobe;
  logic [DATA_W-1:0] mail1Q;
  logic [DATA_W-1:0] mail2Q;

  mbx_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clkA      (clkA),
    .clkB      (clkB),
    .rst1N     (rst1N),
    .rst2N     (rst2N),
    .enA       (enA),
    .wrRdA     (wrRdA),
    .mbA       (mbA),
    .enB       (enB),
    .wrRdB     (wrRdB),
    .mbB       (mbB),
    .strobe    (strobe),
    .mail1FullN(mail1FullN),
    .mail2FullN(mail2FullN)
  );

  mbx_datapath #(.DATA_W(DATA_W)) u_dp (
    .clkA    (clkA),
    .clkB    (clkB),
    .rst1N   (rst1N),
    .rst2N   (rst2N),
    .strobe  (strobe),
    .wrRdA   (wrRdA),
    .mbA     (mbA),
    .aDataIn (aDataIn),
    .fifo2Out(fifo2Out),
    .wrRdB   (wrRdB),
    .mbB     (mbB),
    .bDataIn (bDataIn),
    .fifo1Out(fifo1Out),
    .aDataOut(aDataOut),
    .aOutEn  (aOutEn),
    .bDataOut(bDataOut),
    .bOutEn  (bOutEn),
    .mail1Q  (mail1Q),
    .mail2Q  (mail2Q)
  );

  // A refused load must leave the stored word alone.
  p_blocked_hold_r3: assert property (
    @(posedge clkA) disable iff (!rst1N)
      (enA && wrRdA && mbA && !mail1FullN) |=> $stable(mail1Q)
  );

  p_blocked_hold_r7: assert property (
    @(posedge clkB) disable iff (!rst2N)
      (enB && !wrRdB && mbB && !mail2FullN) |=> $stable(mail2Q)
  );

  // A disabled writer port never changes its outgoing mailbox.
  p_disabled_hold_r11: assert property (
    @(posedge clkA) disable iff (!rst1N) !enA |=> $stable(mail1Q)
  );

endmodule

// File: tb/tb_mbx_dual_mailbox.sv
module tb_mbx_dual_mailbox;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int W = 36;

  logic clkA, clkB, rst1N, rst2N;
  logic enA, wrRdA, mbA, enB, wrRdB, mbB;
  logic [W-1:0] aDataIn, fifo2Out, bDataIn, fifo1Out;
  logic [W-1:0] aDataOut, bDataOut;
  logic aOutEn, bOutEn, mail1FullN, mail2FullN;

  mbx_dual_mailbox dut (
    .clkA(clkA), .clkB(clkB), .rst1N(rst1N), .rst2N(rst2N),
    .enA(enA), .wrRdA(wrRdA), .mbA(mbA), .aDataIn(aDataIn),
    .fifo2Out(fifo2Out), .aDataOut(aDataOut), .aOutEn(aOutEn),
    .mail1FullN(mail1FullN),
    .enB(enB), .wrRdB(wrRdB), .mbB(mbB), .bDataIn(bDataIn),
    .fifo1Out(fifo1Out), .bDataOut(bDataOut), .bOutEn(bOutEn),
    .mail2FullN(mail2FullN)
  );

  // 250 MHz port A clock; port B clock with edges that never meet port A's.
  initial begin
    clkA = 1'b0;
    forever #2 clkA = ~clkA;
  end
  initial begin
    clkB = 1'b0;
    #1.5 clkB = 1'b1;
    forever #3 clkB = ~clkB;
  end

  // Behavioural reference: counts edges since each load and each drain.
  logic         mFlag1, mFlag2;
  logic [W-1:0] mMail1, mMail2;
  int           mPend1, mPend2, mRel1, mRel2;
  int           mSeen1, mSeen2, mAck1, mAck2;
  logic         lastA, lastB;
  initial begin
    lastA = 1'b0; lastB = 1'b0;
    mFlag1 = 1'b1; mFlag2 = 1'b1; mMail1 = '0; mMail2 = '0;
    mPend1 = 0; mPend2 = 0; mRel1 = 0; mRel2 = 0;
    mSeen1 = 0; mSeen2 = 0; mAck1 = 0; mAck2 = 0;
  end

  always @(clkA or clkB or rst1N or rst2N) begin
    automatic logic aRise = clkA && !lastA;
    automatic logic bRise = clkB && !lastB;
    lastA = clkA;
    lastB = clkB;
    if (!rst1N) begin
      mFlag1 = 1'b1; mMail1 = '0; mPend1 = 0; mRel1 = 0; mSeen1 = 0; mAck1 = 0;
    end else begin
      if (aRise) begin
        if (enA && wrRdA && mbA && mFlag1) begin
          mMail1 = aDataIn; mFlag1 = 1'b0; mPend1 = 1; mSeen1 = 0;
        end
        if (mRel1 != 0) begin
          mAck1++;
          if (mAck1 == 2) begin mFlag1 = 1'b1; mRel1 = 0; end
        end
      end
      if (bRise && mPend1 != 0) begin
        if (mSeen1 >= 2 && enB && wrRdB && mbB) begin
          mPend1 = 0; mRel1 = 1; mAck1 = 0;
        end else mSeen1++;
      end
    end
    if (!rst2N) begin
      mFlag2 = 1'b1; mMail2 = '0; mPend2 = 0; mRel2 = 0; mSeen2 = 0; mAck2 = 0;
    end else begin
      if (bRise) begin
        if (enB && !wrRdB && mbB && mFlag2) begin
          mMail2 = bDataIn; mFlag2 = 1'b0; mPend2 = 1; mSeen2 = 0;
        end
        if (mRel2 != 0) begin
          mAck2++;
          if (mAck2 == 2) begin mFlag2 = 1'b1; mRel2 = 0; end
        end
      end
      if (aRise && mPend2 != 0) begin
        if (mSeen2 >= 2 && enA && !wrRdA && mbA) begin
          mPend2 = 0; mRel2 = 1; mAck2 = 0;
        end else mSeen2++;
      end
    end
  end

  int  nChk = 0;
  int  nFail = 0;
  bit  cmpOn = 1'b0;
  bit  done = 1'b0;

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmpAll();
    chk("R2 R3 R4 R5 R11 R12 mail1FullN", W'(mail1FullN), W'(mFlag1));
    chk("R6 R7 R8 R11 R12 mail2FullN",   W'(mail2FullN), W'(mFlag2));
    chk("R9 aOutEn",  W'(aOutEn), W'(!wrRdA));
    chk("R10 bOutEn", W'(bOutEn), W'(wrRdB));
    chk("R9 R6 R7 aDataOut",  aDataOut, mbA ? mMail2 : fifo2Out);
    chk("R10 R2 R3 bDataOut", bDataOut, mbB ? mMail1 : fifo1Out);
  endtask

  task automatic setA(input logic en, input logic wr, input logic mb, input logic [W-1:0] d);
    @(negedge clkA);
    enA = en; wrRdA = wr; mbA = mb; aDataIn = d;
  endtask

  task automatic setB(input logic en, input logic wr, input logic mb, input logic [W-1:0] d);
    @(negedge clkB);
    enB = en; wrRdB = wr; mbB = mb; bDataIn = d;
  endtask

  task automatic waitA(input int n);
    repeat (n) @(posedge clkA);
    #1;
  endtask

  task automatic waitB(input int n);
    repeat (n) @(posedge clkB);
    #1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
  endtask

  initial begin
    enA = 0; wrRdA = 1; mbA = 0; aDataIn = '0; fifo2Out = '0;
    enB = 0; wrRdB = 1; mbB = 0; bDataIn = '0; fifo1Out = '0;
    rst1N = 1; rst2N = 1;

    fork
      begin : watchdog
        #800000;
        if (!done) begin
          nChk++; nFail++;
          $display("FAIL watchdog expired actual=running expected=finished");
          summary();
          $finish;
        end
      end
      begin : monitor
        forever begin
          @(posedge clkA or posedge clkB);
          #1;
          if (cmpOn) cmpAll();
        end
      end
    join_none

    #1 rst1N = 0; rst2N = 0;
    cmpOn = 1'b1;
    repeat (5) @(negedge clkA);
    // R1: reset values with both mailboxes selected for viewing
    mbA = 1; wrRdA = 0;
    #0.5;
    chk("R1 mail1FullN in reset", W'(mail1FullN), W'(1'b1));
    chk("R1 mail2FullN in reset", W'(mail2FullN), W'(1'b1));
    chk("R1 mailbox 2 cleared", aDataOut, '0);
    @(negedge clkA);
    rst1N = 1; rst2N = 1;
    setA(0, 1, 0, '0);

    // R2: port A mailbox write
    setA(1, 1, 1, 36'h0_0000_00A1);
    setA(0, 1, 1, '0);
    waitA(2);
    chk("R2 flag low after load", W'(mail1FullN), W'(1'b0));

    // R3: a second write is refused while full
    setA(1, 1, 1, 36'h0_0000_00B2);
    setA(0, 1, 0, '0);
    setB(0, 1, 1, '0);
    waitB(2);
    chk("R3 mailbox kept first word", bDataOut, 36'h0_0000_00A1);

    // R11: port B read cycles with enable low do not drain
    waitA(8);
    chk("R11 disabled read keeps flag low", W'(mail1FullN), W'(1'b0));

    // R4: port B drains, flag returns after the sync latency
    setB(1, 1, 1, '0);
    setB(0, 1, 1, '0);
    waitA(4);
    chk("R4 flag high after drain", W'(mail1FullN), W'(1'b1));

    // R5: reading an empty mailbox changes nothing
    setB(1, 1, 1, '0);
    setB(0, 1, 1, '0);
    waitA(4);
    chk("R5 empty read keeps flag", W'(mail1FullN), W'(1'b1));
    chk("R5 empty read shows old word", bDataOut, 36'h0_0000_00A1);

    // R11: disabled port A write does not load
    setA(0, 1, 1, 36'h0_0000_00C3);
    setA(0, 1, 0, '0);
    waitA(2);
    chk("R11 disabled write keeps flag", W'(mail1FullN), W'(1'b1));
    chk("R11 disabled write keeps word", bDataOut, 36'h0_0000_00A1);

    // R6: port B mailbox write (wrRdB low)
    setB(1, 0, 1, 36'h9_0000_005E);
    setB(0, 1, 0, '0);
    waitB(1);
    chk("R6 flag2 low after load", W'(mail2FullN), W'(1'b0));
    setA(0, 0, 1, '0);
    waitA(1);
    chk("R9 port A shows mailbox 2", aDataOut, 36'h9_0000_005E);

    // R7: refused port B write
    setB(1, 0, 1, 36'h0_0000_006F);
    setB(0, 1, 0, '0);
    waitA(2);
    chk("R7 mailbox 2 kept first word", aDataOut, 36'h9_0000_005E);

    // R8: port A drains mailbox 2
    setA(1, 0, 1, '0);
    setA(0, 0, 1, '0);
    waitB(4);
    chk("R8 flag2 high after drain", W'(mail2FullN), W'(1'b1));

    // R9 / R10: output selection and enables
    fifo2Out = 36'h1_2345_6789;
    fifo1Out = 36'hF_EDCB_A987;
    setA(0, 0, 0, '0);
    waitA(1);
    chk("R9 FIFO word on port A", aDataOut, 36'h1_2345_6789);
    chk("R9 port A enabled in read", W'(aOutEn), W'(1'b1));
    setA(0, 1, 0, '0);
    waitA(1);
    chk("R9 port A disabled in write", W'(aOutEn), W'(1'b0));
    setB(0, 1, 0, '0);
    waitB(1);
    chk("R10 FIFO word on port B", bDataOut, 36'hF_EDCB_A987);
    setB(0, 0, 0, '0);
    waitB(1);
    chk("R10 port B disabled in write", W'(bOutEn), W'(1'b0));

    // R2 R4 R5: writer retries every edge against a reader polling every edge
    fork
      begin
        for (int i = 0; i < 60; i++) setA(1, 1, 1, W'(36'h100 + i));
        setA(0, 1, 0, '0);
      end
      begin
        for (int i = 0; i < 40; i++) setB(1, 1, 1, '0);
        setB(0, 1, 0, '0);
      end
    join
    waitA(10);

    // R6 R8: the mirrored collision on mailbox 2
    fork
      begin
        for (int i = 0; i < 40; i++) setB(1, 0, 1, W'(36'h200 + i));
        setB(0, 1, 0, '0);
      end
      begin
        for (int i = 0; i < 60; i++) setA(1, 0, 1, '0);
        setA(0, 1, 0, '0);
      end
    join
    waitB(10);

    // R12: resetting mailbox 1 leaves mailbox 2 alone
    setA(1, 1, 1, 36'h0_0000_0077);
    setA(0, 1, 0, '0);
    setB(1, 0, 1, 36'h0_0000_0088);
    setB(0, 1, 1, '0);
    waitA(3);
    chk("R12 mailbox 1 full before reset", W'(mail1FullN), W'(1'b0));
    @(negedge clkA);
    rst1N = 0;
    waitA(2);
    chk("R12 flag1 forced high", W'(mail1FullN), W'(1'b1));
    chk("R12 mailbox 1 cleared", bDataOut, '0);
    chk("R12 flag2 untouched", W'(mail2FullN), W'(1'b0));
    @(negedge clkA);
    rst1N = 1;
    setA(0, 0, 1, '0);
    waitA(2);
    chk("R12 mailbox 2 word kept", aDataOut, 36'h0_0000_0088);

    waitA(4);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule